// File: doc/BRIEF.md
# Three-Tier Vectored Interrupt Controller

This block gathers level-sensitive request lines from peripherals and turns them into the two request inputs of a processor. One is a fast request and the other is a normal request. Software sorts every source into one of two classes with a per-source class bit. Sources in the fast class drive only the fast request. All other enabled sources drive the normal request.

Within the normal class, up to 16 programmable vector slots give a fixed priority order. Each slot holds a handler address, a source index and an enable bit. Any source may be tied to any slot. When the processor reads the vector register, it receives the handler address of the best slot whose source is requesting. If no slot is requesting, it receives one shared default address, which serves every normal source that has no slot. Status words show the raw lines, the active fast sources and the active normal sources.

All priority resolution is combinational. Only the bus read data is registered.

Top module: `irq_vector_ctrl`

Register word offsets on `bus_addr`:
- 0x00: raw lines.
- 0x01: fast status.
- 0x02: normal status.
- 0x03: enable. A read returns the mask; a write sets bits.
- 0x04: enable clear (write only).
- 0x05: class select.
- 0x06: vector address.
- 0x07: default address.
- 0x10+n: handler address of slot n.
- 0x20+n: control of slot n.

## Requirements
- R1: After reset, all enables, class bits, slot controls and the default address are zero. `fiq_req` and `irq_req` are low whatever the lines do, and `bus_rdata` is zero.
- R2: `fiq_req` is the OR over sources of line AND enable AND class bit. The class bit is 1 for fast, set at offset 0x05. Reading offset 0x01 returns that per-source vector.
- R3: `irq_req` is the OR over sources of line AND enable AND NOT class bit. Reading offset 0x02 returns that per-source vector.
- R4: Reading offset 0x00 returns the request lines unmasked, including lines that are disabled.
- R5: Writing offset 0x03 sets the enable bits that are 1 in the data and leaves the others unchanged. Writing offset 0x04 clears the enable bits that are 1 and leaves the others unchanged. Reading 0x03 returns the mask.
- R6: A source whose class bit is 1 never raises `irq_req` and never wins a vector slot, even if a slot names it.
- R7: Reading offset 0x06 returns the handler address, offset 0x10+n, of the lowest-numbered slot n that meets three conditions. The slot's enable bit (bit 5 of offset 0x20+n) is 1. The source selected by bits 4:0 of that control word is requesting. That source is enabled and in the normal class.
- R8: A slot whose enable bit is 0 never wins, even when its source is active.
- R9: When no slot qualifies, reading offset 0x06 returns the default address stored at offset 0x07. This includes the case where only slot-less normal sources are active.
- R10: A write to offset 0x06 marks end of service. It changes neither output, nor any register value, nor later vector reads.
- R11: Read data appears on `bus_rdata` the cycle after the read strobe. It holds until the next read, even if the request lines change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_SRC | Level request lines from peripherals |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Register word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| fiq_req | output | 1 | Fast request to the processor |
| irq_req | output | 1 | Normal request to the processor |

## Verification
The hardest case to reach is a contest between several qualifying slots, with a disabled slot or a fast-class source sitting above the intended winner. The vector read must skip those and return the right address. The bench programs slots 1, 3, 7, 9 and 15 so that they overlap on shared sources. It then walks the line pattern through cases where a disabled slot, a fast source, or no slot at all sits in front of the expected winner. Between cases it re-enables slot 1, to show that the same source then moves to the higher slot.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  localparam int unsigned REG_AW = 6;

  typedef enum logic [3:0] {
    RK_RAW, RK_FAST, RK_NORM, RK_EN_SET, RK_EN_CLR,
    RK_CLASS, RK_VEC, RK_DFLT, RK_SLOT_ADDR, RK_SLOT_CTL, RK_NONE
  } reg_kind_t;

  localparam logic [REG_AW-1:0] OFS_VEC = 6'h06;

  // Map a word offset to the register it selects.
  function automatic reg_kind_t decode_reg(input logic [REG_AW-1:0] a);
    reg_kind_t k;
    case (a[5:4])
      2'b00: begin
        case (a[3:0])
          4'h0: k = RK_RAW;
          4'h1: k = RK_FAST;
          4'h2: k = RK_NORM;
          4'h3: k = RK_EN_SET;
          4'h4: k = RK_EN_CLR;
          4'h5: k = RK_CLASS;
          4'h6: k = RK_VEC;
          4'h7: k = RK_DFLT;
          default: k = RK_NONE;
        endcase
      end
      2'b01:   k = RK_SLOT_ADDR;
      2'b10:   k = RK_SLOT_CTL;
      default: k = RK_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/ivc_classify.sv
module ivc_classify #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0] lines,
  input  logic [NUM_SRC-1:0] enable,
  input  logic [NUM_SRC-1:0] fast_sel,
  output logic [NUM_SRC-1:0] fast_vec,
  output logic [NUM_SRC-1:0] norm_vec
);
  logic [NUM_SRC-1:0] masked;
  assign masked   = lines & enable;
  assign fast_vec = masked & fast_sel;
  assign norm_vec = masked & ~fast_sel;
endmodule

// File: rtl/ivc_slot_match.sv
module ivc_slot_match #(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned NUM_SLOT = 16,
  localparam int unsigned SRC_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]                norm_vec,
  input  logic [NUM_SLOT-1:0]               slot_en,
  input  logic [NUM_SLOT-1:0][SRC_W-1:0]    slot_src,
  output logic [NUM_SLOT-1:0]               slot_hit
);
  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    assign slot_hit[s] = slot_en[s] & norm_vec[slot_src[s]];
  end
endmodule

// File: rtl/ivc_prio.sv
module ivc_prio #(
  parameter int unsigned NUM_SLOT = 16,
  localparam int unsigned SLOT_W  = $clog2(NUM_SLOT)
) (
  input  logic [NUM_SLOT-1:0] hit,
  output logic                win_valid,
  output logic [SLOT_W-1:0]   win_idx
);
  // Lowest set index wins: scan from the top so the last match is the lowest.
  function automatic logic [SLOT_W-1:0] lowest_index(input logic [NUM_SLOT-1:0] h);
    logic [SLOT_W-1:0] idx;
    idx = '0;
    for (int i = NUM_SLOT - 1; i >= 0; i--) begin
      if (h[i]) idx = SLOT_W'(i);
    end
    return idx;
  endfunction

  assign win_valid = |hit;
  assign win_idx   = lowest_index(hit);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned NUM_SLOT = 16,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   irq_lines,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [5:0]           bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 fiq_req,
  output logic                 irq_req
);
  import ivc_pkg::*;

  localparam int unsigned SRC_W  = $clog2(NUM_SRC);
  localparam int unsigned SLOT_W = $clog2(NUM_SLOT);

  // Programmable state
  logic [NUM_SRC-1:0]                en_q;
  logic [NUM_SRC-1:0]                sel_q;
  logic [DATA_W-1:0]                 dflt_q;
  logic [NUM_SLOT-1:0]               slot_en_q;
  logic [NUM_SLOT-1:0][SRC_W-1:0]    slot_src_q;
  logic [NUM_SLOT-1:0][DATA_W-1:0]   slot_addr_q;
  logic [DATA_W-1:0]                 rdata_q;

  // Named internal events for the checker
  logic [NUM_SRC-1:0]  fiq_vec;
  logic [NUM_SRC-1:0]  irq_vec;
  logic [NUM_SLOT-1:0] slot_hit;
  logic                win_valid;
  logic [SLOT_W-1:0]   win_idx;
  logic [DATA_W-1:0]   vec_live;
  reg_kind_t           kind;
  logic [SLOT_W-1:0]   slot_sel;

  assign kind     = decode_reg(bus_addr);
  assign slot_sel = bus_addr[SLOT_W-1:0];

  ivc_classify #(.NUM_SRC(NUM_SRC)) u_classify (
    .lines    (irq_lines),
    .enable   (en_q),
    .fast_sel (sel_q),
    .fast_vec (fiq_vec),
    .norm_vec (irq_vec)
  );

  ivc_slot_match #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) u_match (
    .norm_vec (irq_vec),
    .slot_en  (slot_en_q),
    .slot_src (slot_src_q),
    .slot_hit (slot_hit)
  );

  ivc_prio #(.NUM_SLOT(NUM_SLOT)) u_prio (
    .hit       (slot_hit),
    .win_valid (win_valid),
    .win_idx   (win_idx)
  );

  assign fiq_req  = |fiq_vec;
  assign irq_req  = |irq_vec;
  assign vec_live = win_valid ? slot_addr_q[win_idx] : dflt_q;

  // Register writes. A write to the vector offset is end-of-service and has no effect.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q        <= '0;
      sel_q       <= '0;
      dflt_q      <= '0;
      slot_en_q   <= '0;
      slot_src_q  <= '0;
      slot_addr_q <= '0;
    end else if (bus_wr) begin
      case (kind)
        RK_EN_SET:    en_q   <= en_q | bus_wdata[NUM_SRC-1:0];
        RK_EN_CLR:    en_q   <= en_q & ~bus_wdata[NUM_SRC-1:0];
        RK_CLASS:     sel_q  <= bus_wdata[NUM_SRC-1:0];
        RK_DFLT:      dflt_q <= bus_wdata;
        RK_SLOT_ADDR: slot_addr_q[slot_sel] <= bus_wdata;
        RK_SLOT_CTL: begin
          slot_en_q[slot_sel]  <= bus_wdata[SRC_W];
          slot_src_q[slot_sel] <= bus_wdata[SRC_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // Read mux, captured on the read strobe
  logic [DATA_W-1:0] rdata_d;
  always_comb begin
    rdata_d = '0;
    case (kind)
      RK_RAW:       rdata_d = DATA_W'(irq_lines);
      RK_FAST:      rdata_d = DATA_W'(fiq_vec);
      RK_NORM:      rdata_d = DATA_W'(irq_vec);
      RK_EN_SET:    rdata_d = DATA_W'(en_q);
      RK_CLASS:     rdata_d = DATA_W'(sel_q);
      RK_VEC:       rdata_d = vec_live;
      RK_DFLT:      rdata_d = dflt_q;
      RK_SLOT_ADDR: rdata_d = slot_addr_q[slot_sel];
      RK_SLOT_CTL:  rdata_d = DATA_W'({slot_en_q[slot_sel], slot_src_q[slot_sel]});
      default:      rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned NUM_SLOT = 16,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned SLOT_W  = $clog2(NUM_SLOT)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_rd,
  input logic                bus_wr,
  input logic [5:0]          bus_addr,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                fiq_req,
  input logic                irq_req,
  input logic [NUM_SRC-1:0]  fiq_vec,
  input logic [NUM_SRC-1:0]  irq_vec,
  input logic [NUM_SLOT-1:0] slot_hit,
  input logic                win_valid,
  input logic [SLOT_W-1:0]   win_idx,
  input logic [NUM_SLOT-1:0] slot_en_q,
  input logic [NUM_SRC-1:0]  en_q,
  input logic [NUM_SRC-1:0]  sel_q,
  input logic [DATA_W-1:0]   dflt_q
);
  logic [NUM_SLOT-1:0] below_win;
  always_comb begin
    for (int i = 0; i < NUM_SLOT; i++) below_win[i] = (i < int'(win_idx));
  end

  AST_FIQ_NEEDS_FAST_EN: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_req |-> ((en_q & sel_q) != '0)); // R2
  AST_IRQ_NEEDS_NORM_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((en_q & ~sel_q) != '0)); // R3
  AST_CLASS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_vec & irq_vec) == '0); // R6
  AST_WIN_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> irq_req); // R7
  AST_WIN_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (slot_hit[win_idx] && ((slot_hit & below_win) == '0))); // R7
  AST_WIN_SLOT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> slot_en_q[win_idx]); // R8
  AST_DEFAULT_WHEN_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ivc_pkg::OFS_VEC && !win_valid) |=> (bus_rdata == $past(dflt_q))); // R9
  AST_EOS_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_addr == ivc_pkg::OFS_VEC) |=>
      ($stable(en_q) && $stable(sel_q) && $stable(slot_en_q) && $stable(dflt_q))); // R10
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R11
endmodule

bind irq_vector_ctrl ivc_checker #(
  .NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .fiq_req(fiq_req), .irq_req(irq_req), .fiq_vec(fiq_vec),
  .irq_vec(irq_vec), .slot_hit(slot_hit), .win_valid(win_valid), .win_idx(win_idx),
  .slot_en_q(slot_en_q), .en_q(en_q), .sel_q(sel_q), .dflt_q(dflt_q)
);

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;
  localparam int NS = 32;
  localparam int NSL = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fiq_req, irq_req;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_vector_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fiq_req(fiq_req), .irq_req(irq_req)
  );

  // Bench-side model
  logic [31:0] m_en = '0, m_sel = '0, m_dflt = '0;
  logic        m_sen [NSL];
  logic [4:0]  m_ssrc [NSL];
  logic [31:0] m_saddr [NSL];

  function automatic logic [31:0] model_vec();
    logic [31:0] r;
    r = m_dflt;
    for (int s = NSL - 1; s >= 0; s--) begin
      if (m_sen[s] && irq_lines[m_ssrc[s]] && m_en[m_ssrc[s]] && !m_sel[m_ssrc[s]])
        r = m_saddr[s];
    end
    return r;
  endfunction

  // Scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        chk_now = 1'b0;

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  always @(posedge clk) chk_now <= bus_rd;
  always @(negedge clk) begin
    if (chk_now) begin
      if (exp_q.size() == 0) check(1, 0, "scoreboard underflow");
      else check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic en_set(input logic [31:0] m); wr(6'h03, m); m_en = m_en | m; endtask
  task automatic en_clr(input logic [31:0] m); wr(6'h04, m); m_en = m_en & ~m; endtask
  task automatic slot(input int s, input logic en, input logic [4:0] src, input logic [31:0] a);
    wr(6'h10 + 6'(s), a);
    wr(6'h20 + 6'(s), {26'd0, en, src});
    m_sen[s] = en; m_ssrc[s] = src; m_saddr[s] = a;
  endtask

  task automatic drive(input logic [31:0] v, input string tag);
    @(negedge clk);
    irq_lines = v;
    #1;
    check(32'(fiq_req), 32'(|(v & m_en & m_sel)), {tag, " R2 fiq"});
    check(32'(irq_req), 32'(|(v & m_en & ~m_sel)), {tag, " R3 irq"});
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
    end
  end

  initial begin
    for (int s = 0; s < NSL; s++) begin m_sen[s] = 0; m_ssrc[s] = 0; m_saddr[s] = 0; end
    irq_lines = 32'h0000_00A5;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1: outputs idle and read data zero after reset
    check(32'(fiq_req), 0, "R1 fiq after reset");
    check(32'(irq_req), 0, "R1 irq after reset");
    check(bus_rdata, 0, "R1 rdata after reset");
    rd(6'h03, 0, "R1 enable reset");
    rd(6'h05, 0, "R1 class reset");
    rd(6'h07, 0, "R1 default reset");
    rd(6'h00, 32'h0000_00A5, "R4 raw unmasked");
    rd(6'h02, 0, "R3 norm status all disabled");

    // R5: set-only and clear-only enable ports
    en_set(32'h0000_00F0);
    en_set(32'h0000_0003);
    rd(6'h03, 32'h0000_00F3, "R5 enable after sets");
    en_clr(32'h0000_0010);
    rd(6'h03, 32'h0000_00E3, "R5 enable after clear");

    // R2/R3: class split
    wr(6'h05, 32'h0000_0020); m_sel = 32'h0000_0020;
    drive(32'h0000_0024, "fast only");
    rd(6'h01, 32'h0000_0020, "R2 fast status");
    rd(6'h02, 32'h0000_0000, "R3 norm status empty");
    drive(32'h0000_0041, "normal pair");
    rd(6'h02, 32'h0000_0041, "R3 norm status");
    rd(6'h00, 32'h0000_0041, "R4 raw");

    // Slots
    wr(6'h07, 32'hDEAD_0000); m_dflt = 32'hDEAD_0000;
    slot(3, 1'b1, 5'd6, 32'h1000_0300);
    slot(7, 1'b1, 5'd0, 32'h1000_0700);
    slot(1, 1'b0, 5'd0, 32'h1000_0100);
    slot(9, 1'b1, 5'd5, 32'h1000_0900);
    slot(15, 1'b1, 5'd7, 32'h1000_0F00);
    rd(6'h21, 32'h0000_0000, "R8 slot1 ctl readback");
    rd(6'h23, 32'h0000_0026, "R7 slot3 ctl readback");

    drive(32'h0000_0041, "slots 3 and 7");
    rd(6'h06, model_vec(), "R7 slot3 beats slot7, R8 slot1 off");
    check(model_vec(), 32'h1000_0300, "R7 model sanity");
    drive(32'h0000_0001, "src0 only");
    rd(6'h06, 32'h1000_0700, "R8 disabled slot1 skipped");
    drive(32'h0000_0002, "no slot source");
    rd(6'h06, 32'hDEAD_0000, "R9 default address");
    drive(32'h0000_0020, "fast source in slot9");
    rd(6'h06, 32'hDEAD_0000, "R6 fast source not vectored");
    drive(32'h0000_0080, "src7 lowest slot");
    rd(6'h06, 32'h1000_0F00, "R7 slot15");
    drive(32'h0000_00A1, "fast plus src7 plus src0");
    rd(6'h06, 32'h1000_0700, "R6 R7 slot7 wins");

    slot(1, 1'b1, 5'd0, 32'h1000_0100);
    drive(32'h0000_0041, "slot1 enabled");
    rd(6'h06, 32'h1000_0100, "R7 slot1 now wins");

    // R11: read data holds after the read
    irq_lines = 32'h0000_0002;
    repeat (3) @(negedge clk);
    check(bus_rdata, 32'h1000_0100, "R11 rdata holds");

    // R10: end-of-service write
    drive(32'h0000_0021, "before eos");
    wr(6'h06, 32'hFFFF_FFFF);
    #1;
    check(32'(fiq_req), 1, "R10 fiq unchanged");
    check(32'(irq_req), 1, "R10 irq unchanged");
    rd(6'h03, 32'h0000_00E3, "R10 enable unchanged");
    rd(6'h06, 32'h1000_0100, "R10 vector unchanged");
    en_clr(32'hFFFF_FFFF);
    drive(32'h0000_00FF, "all disabled");

    repeat (2) @(negedge clk);
    check(32'(exp_q.size()), 0, "scoreboard drained");
    done = 1'b1;
    summary();
  end
endmodule